// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Sweep Engine

This block keeps the synaptic current and membrane voltage of a small array of leaky integrate-and-fire neurons in registers. It advances them one time-step at a time. A single-cycle strobe starts a sweep that visits neurons 0 through N-1, one per clock. While neuron k is visited, the block reads the signed activation presented on `act_i`. It then updates that neuron with integer arithmetic that is exact to the bit. The result is emitted one cycle later: the spike bit, the neuron index, the new current and the new voltage.

Five shared parameters load through a small write port: two decay constants, a bias mantissa, a bias exponent and a threshold mantissa. For the current, a one-bit offset of 1 is added to its decay constant, so the current can decay completely to zero. The voltage has no such offset, so a decay constant of 0 leaves it unchanged. The activation and the threshold are shifted left for MSB alignment. The current wraps on overflow, the voltage saturates, and a neuron that fires has its voltage cleared in the same update.

Top module: `lif_sweep_engine`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `out_valid_o`, `spike_o` and `done_o` are 0, and every neuron's current and voltage is cleared to 0.
- R2: A one-cycle `step_i` sampled while idle raises `busy_o` with `idx_o`=0. The index then advances by one per cycle through N-1. `act_i` is sampled in the cycle where `idx_o`=k, and the result for neuron k appears the next cycle with `out_valid_o`=1 and `out_idx_o`=k.
- R3: `done_o` pulses for one cycle, together with the output for neuron N-1. `busy_o` falls after that last neuron.
- R4: `step_i` asserted while a sweep is running is ignored: the index keeps advancing and no neuron is processed twice.
- R5: New current u' = D(u, 4096-(du+1)) + act*64. Here D(x,f) = sign(x)*((|x|*f)>>12), which rounds toward zero.
- R6: If the sum in R5 leaves the 24-bit range, the sign is kept and the magnitude is reduced modulo 2^23. A positive 2^23+k becomes k, a negative -(2^23+k) becomes -k, and zero stays zero. `u_o` is never -2^23.
- R7: New voltage is D(v, 4096-dv) + u' + (bias_mantissa << bias_exponent), saturated to the range [-2^23, 2^23-1].
- R8: A spike occurs only when the saturated voltage is strictly greater than vth*64. A neuron that spikes stores and reports voltage 0; its current is unaffected.
- R9: A write with `wr_en_i`=1 sets a field selected by `wr_addr_i`. Address 0 sets the current decay (data[11:0]) and address 1 the voltage decay (data[11:0]). Address 2 sets the bias mantissa (data[12:0], two's complement), address 3 the bias exponent (data[2:0]) and address 4 the threshold mantissa (data[16:0]). All fields reset to 0.
- R10: Each neuron's current and voltage persist from one sweep to the next, and are changed only when that neuron is visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Time-step strobe, starts a sweep when idle |
| wr_en_i | input | 1 | Parameter write enable |
| wr_addr_i | input | 3 | Parameter select |
| wr_data_i | input | 17 | Parameter write data |
| act_i | input | 16 | Signed activation for the neuron shown on idx_o |
| busy_o | output | 1 | Sweep in progress |
| idx_o | output | 3 | Neuron being processed this cycle |
| out_valid_o | output | 1 | Result outputs are valid |
| out_idx_o | output | 3 | Neuron index of the result |
| spike_o | output | 1 | Neuron fired |
| u_o | output | 24 | Updated current (signed) |
| v_o | output | 24 | Updated voltage after reset-on-spike (signed) |
| done_o | output | 1 | Sweep complete, coincides with the last result |

## Verification
Two things can land in the same cycle. First, a new strobe can arrive in the middle of a running sweep. The bench pulses `step_i` while neuron 3 is being processed and expects the index to carry on without a restart. Second, a neuron's voltage can hit the positive saturation limit in the same update in which it crosses the maximum threshold. A mantissa of 4095 at exponent 7, with no voltage decay, pushes the raw sum past 2^23-1. The bench expects a spike together with a reported voltage of 0. The reference model compares every output field on every clock.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int unsigned CFG_ADDR_W = 3;
  localparam int unsigned CFG_DATA_W = 17;
  localparam int unsigned DECAY_W    = 12;
  localparam int unsigned BMAN_W     = 13;
  localparam int unsigned BEXP_W     = 3;
  localparam int unsigned VTH_W      = 17;

  typedef enum logic [CFG_ADDR_W-1:0] {
    SEL_DU   = 3'd0,
    SEL_DV   = 3'd1,
    SEL_BMAN = 3'd2,
    SEL_BEXP = 3'd3,
    SEL_VTH  = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic [DECAY_W-1:0] du;
    logic [DECAY_W-1:0] dv;
    logic [BMAN_W-1:0]  bman;
    logic [BEXP_W-1:0]  bexp;
    logic [VTH_W-1:0]   vth;
  } cfg_t;
endpackage

// File: rtl/lif_decay.sv
module lif_decay #(
  parameter int unsigned STATE_W = 24,
  parameter int unsigned DECAY_W = 12,
  parameter int unsigned OFFSET  = 0
) (
  input  logic signed [STATE_W-1:0] x_i,
  input  logic        [DECAY_W-1:0] d_i,
  output logic signed [STATE_W-1:0] y_o
);
  localparam int unsigned FAC_W  = DECAY_W + 1;
  localparam int unsigned PROD_W = STATE_W + FAC_W;

  logic               neg;
  logic [STATE_W-1:0] mag;
  logic [FAC_W-1:0]   fac;
  logic [PROD_W-1:0]  prod;
  logic [STATE_W-1:0] res;

  // magnitude scaled then truncated: rounds toward zero
  always_comb begin
    neg  = x_i[STATE_W-1];
    mag  = neg ? STATE_W'(-x_i) : STATE_W'(x_i);
    fac  = FAC_W'(1 << DECAY_W) - FAC_W'(d_i) - FAC_W'(OFFSET);
    prod = PROD_W'(mag) * PROD_W'(fac);
    res  = STATE_W'(prod >> DECAY_W);
    y_o  = neg ? -$signed(res) : $signed(res);
  end
endmodule

// File: rtl/lif_neuron_dp.sv
module lif_neuron_dp
  import lif_pkg::*;
#(
  parameter int unsigned STATE_W   = 24,
  parameter int unsigned ACT_W     = 16,
  parameter int unsigned ACT_SHIFT = 6,
  parameter int unsigned VTH_SHIFT = 6
) (
  input  logic signed [STATE_W-1:0] u_i,
  input  logic signed [STATE_W-1:0] v_i,
  input  logic signed [ACT_W-1:0]   act_i,
  input  cfg_t                      cfg_i,
  output logic signed [STATE_W-1:0] u_o,
  output logic signed [STATE_W-1:0] v_o,
  output logic                      spike_o
);
  localparam int unsigned SUM_W = STATE_W + 3;
  localparam int unsigned EXT_W = SUM_W - STATE_W;
  localparam logic signed [SUM_W-1:0] V_HI = SUM_W'((64'd1 << (STATE_W-1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] V_LO = -V_HI - SUM_W'(1);

  logic signed [STATE_W-1:0] u_dec, v_dec, u_new, v_sat;
  logic signed [SUM_W-1:0]   act_al, u_raw, v_raw, v_clip, bias_eff, thr;
  logic        [SUM_W-1:0]   u_mag;
  logic        [STATE_W-2:0] u_low;

  lif_decay #(.STATE_W(STATE_W), .DECAY_W(DECAY_W), .OFFSET(1)) u_decay_cur (
    .x_i(u_i), .d_i(cfg_i.du), .y_o(u_dec)
  );

  lif_decay #(.STATE_W(STATE_W), .DECAY_W(DECAY_W), .OFFSET(0)) u_decay_vol (
    .x_i(v_i), .d_i(cfg_i.dv), .y_o(v_dec)
  );

  always_comb begin
    act_al = $signed({{(SUM_W-ACT_W){act_i[ACT_W-1]}}, act_i}) <<< ACT_SHIFT;
    u_raw  = $signed({{EXT_W{u_dec[STATE_W-1]}}, u_dec}) + act_al;
    // sign-preserving wrap: keep magnitude modulo 2^(STATE_W-1)
    u_mag  = u_raw[SUM_W-1] ? SUM_W'(-u_raw) : SUM_W'(u_raw);
    u_low  = (STATE_W-1)'(u_mag);
    u_new  = u_raw[SUM_W-1] ? -$signed({1'b0, u_low}) : $signed({1'b0, u_low});

    bias_eff = $signed({{(SUM_W-BMAN_W){cfg_i.bman[BMAN_W-1]}}, cfg_i.bman}) <<< cfg_i.bexp;
    v_raw    = $signed({{EXT_W{v_dec[STATE_W-1]}}, v_dec})
             + $signed({{EXT_W{u_new[STATE_W-1]}}, u_new}) + bias_eff;
    if (v_raw > V_HI)      v_clip = V_HI;
    else if (v_raw < V_LO) v_clip = V_LO;
    else                   v_clip = v_raw;
    v_sat = STATE_W'(v_clip);

    thr     = $signed({{(SUM_W-VTH_W){1'b0}}, cfg_i.vth}) <<< VTH_SHIFT;
    spike_o = v_clip > thr;
    u_o     = u_new;
    v_o     = spike_o ? '0 : v_sat;
  end
endmodule

// File: rtl/lif_sweep_ctrl.sv
module lif_sweep_ctrl #(
  parameter int unsigned N_NEURONS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  assign last_o = busy_o && (idx_o == IDX_W'(N_NEURONS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else if (step_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end
  end

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o && idx_o == IDX_W'($past(idx_o) + 1'b1));

  p_end_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);

  p_step_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && step_i && !last_o |=> idx_o != '0);
endmodule

// File: rtl/lif_sweep_engine.sv
module lif_sweep_engine
  import lif_pkg::*;
#(
  parameter int unsigned N_NEURONS = 8,
  parameter int unsigned STATE_W   = 24,
  parameter int unsigned ACT_W     = 16,
  parameter int unsigned ACT_SHIFT = 6,
  parameter int unsigned VTH_SHIFT = 6,
  localparam int unsigned IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      step_i,
  input  logic                      wr_en_i,
  input  logic [CFG_ADDR_W-1:0]     wr_addr_i,
  input  logic [CFG_DATA_W-1:0]     wr_data_i,
  input  logic signed [ACT_W-1:0]   act_i,
  output logic                      busy_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic                      out_valid_o,
  output logic [IDX_W-1:0]          out_idx_o,
  output logic                      spike_o,
  output logic signed [STATE_W-1:0] u_o,
  output logic signed [STATE_W-1:0] v_o,
  output logic                      done_o
);
  cfg_t cfg_q;
  logic last;
  logic [N_NEURONS-1:0][STATE_W-1:0] u_all, v_all;
  logic signed [STATE_W-1:0] u_cur, v_cur, u_nxt, v_nxt;
  logic spike_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        SEL_DU:   cfg_q.du   <= wr_data_i[DECAY_W-1:0];
        SEL_DV:   cfg_q.dv   <= wr_data_i[DECAY_W-1:0];
        SEL_BMAN: cfg_q.bman <= wr_data_i[BMAN_W-1:0];
        SEL_BEXP: cfg_q.bexp <= wr_data_i[BEXP_W-1:0];
        SEL_VTH:  cfg_q.vth  <= wr_data_i[VTH_W-1:0];
        default: ;
      endcase
    end
  end

  lif_sweep_ctrl #(.N_NEURONS(N_NEURONS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i),
    .busy_o(busy_o), .idx_o(idx_o), .last_o(last)
  );

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_cell
    logic [STATE_W-1:0] u_r, v_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        u_r <= '0;
        v_r <= '0;
      end else if (busy_o && idx_o == IDX_W'(g)) begin
        u_r <= u_nxt;
        v_r <= v_nxt;
      end
    end
    assign u_all[g] = u_r;
    assign v_all[g] = v_r;
  end

  assign u_cur = $signed(u_all[idx_o]);
  assign v_cur = $signed(v_all[idx_o]);

  lif_neuron_dp #(
    .STATE_W(STATE_W), .ACT_W(ACT_W), .ACT_SHIFT(ACT_SHIFT), .VTH_SHIFT(VTH_SHIFT)
  ) u_dp (
    .u_i(u_cur), .v_i(v_cur), .act_i(act_i), .cfg_i(cfg_q),
    .u_o(u_nxt), .v_o(v_nxt), .spike_o(spike_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      spike_o     <= 1'b0;
      u_o         <= '0;
      v_o         <= '0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= busy_o;
      out_idx_o   <= idx_o;
      spike_o     <= busy_o && spike_nxt;
      u_o         <= u_nxt;
      v_o         <= v_nxt;
      done_o      <= last;
    end
  end

  p_spike_clears_v_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && spike_o |-> v_o == '0);

  p_quiet_below_thr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !spike_o |->
      $signed({1'b0, v_o}) <= $signed({1'b0, STATE_W'($past(cfg_q.vth)) << VTH_SHIFT})
      || v_o[STATE_W-1]);

  p_done_with_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o && out_idx_o == IDX_W'(N_NEURONS - 1));

  p_idx_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(out_valid_o) |-> out_idx_o == IDX_W'($past(out_idx_o) + 1'b1));

  p_no_min_current_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> u_o != {1'b1, {(STATE_W-1){1'b0}}});
endmodule

// File: tb/lif_sweep_engine_test.sv
`timescale 1ns/1ps
module lif_sweep_engine_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [16:0] wr_data_i = '0;
  logic signed [15:0] act_i = '0;
  logic busy_o, out_valid_o, spike_o, done_o;
  logic [2:0] idx_o, out_idx_o;
  logic signed [23:0] u_o, v_o;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  lif_sweep_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .act_i(act_i), .busy_o(busy_o), .idx_o(idx_o),
    .out_valid_o(out_valid_o), .out_idx_o(out_idx_o), .spike_o(spike_o),
    .u_o(u_o), .v_o(v_o), .done_o(done_o)
  );

  // reference model state
  longint mu [N];
  longint mv [N];
  longint c_du, c_dv, c_bm, c_be, c_vth;
  bit     m_busy;
  int     m_idx;
  bit     e_valid, e_done, e_spike;
  int     e_idx;
  longint e_u, e_v;

  function automatic longint decay(longint x, longint f);
    longint m;
    m = (x < 0) ? -x : x;
    m = (m * f) / 4096;
    return (x < 0) ? -m : m;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin mu[i] = 0; mv[i] = 0; end
      c_du = 0; c_dv = 0; c_bm = 0; c_be = 0; c_vth = 0;
      m_busy = 0; m_idx = 0;
      e_valid = 0; e_done = 0; e_spike = 0; e_idx = 0; e_u = 0; e_v = 0;
    end else begin
      longint ur, un, vr;
      e_valid = m_busy;
      e_done  = 0;
      e_spike = 0;
      if (m_busy) begin
        ur = decay(mu[m_idx], 4096 - (c_du + 1)) + longint'(act_i) * 64;
        if (ur > 0)      un = ur % 8388608;
        else if (ur < 0) un = -((-ur) % 8388608);
        else             un = 0;
        vr = decay(mv[m_idx], 4096 - c_dv) + un + c_bm * (longint'(1) << c_be);
        if (vr > 8388607)  vr = 8388607;
        if (vr < -8388608) vr = -8388608;
        e_spike = vr > c_vth * 64;
        if (e_spike) vr = 0;
        mu[m_idx] = un;
        mv[m_idx] = vr;
        e_idx = m_idx; e_u = un; e_v = vr;
        e_done = (m_idx == N - 1);
        if (m_idx == N - 1) begin m_busy = 0; m_idx = 0; end
        else m_idx = m_idx + 1;
      end else if (step_i) begin
        m_busy = 1; m_idx = 0;
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: c_du = longint'(wr_data_i[11:0]);
          3'd1: c_dv = longint'(wr_data_i[11:0]);
          3'd2: c_bm = (wr_data_i[12]) ? longint'(wr_data_i[12:0]) - 8192 : longint'(wr_data_i[12:0]);
          3'd3: c_be = longint'(wr_data_i[2:0]);
          3'd4: c_vth = longint'(wr_data_i);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_ni) begin
      chk("R1 busy in reset", busy_o, 0);
      chk("R1 valid in reset", out_valid_o, 0);
      chk("R1 done in reset", done_o, 0);
    end else begin
      chk("R2 R4 busy", busy_o, m_busy);
      if (m_busy) chk("R2 R4 idx", idx_o, m_idx);
      chk("R2 out_valid", out_valid_o, e_valid);
      chk("R3 done", done_o, e_done);
      if (e_valid) begin
        chk("R2 out_idx", out_idx_o, e_idx);
        chk("R8 R9 spike", spike_o, e_spike);
        chk("R5 R6 R10 current", u_o, e_u);
        chk("R7 R9 R10 voltage", v_o, e_v);
      end
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'(addr); wr_data_i = 17'(data);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic logic signed [15:0] pat(input int mode, input int k);
    case (mode)
      0: return 16'sd0;
      1: return 16'(k * 700 - 2500);
      2: return 16'sd32767;
      3: return (k % 2) ? -16'sd32768 : 16'sd32767;
      4: return 16'(5 + k);
      default: return 16'sd0;
    endcase
  endfunction

  // one sweep; glitch_at >= 0 pulses step_i mid-sweep (R4)
  task automatic sweep(input int mode, input int glitch_at);
    @(negedge clk);
    step_i = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      step_i = (k == glitch_at);
      act_i = pat(mode, k);
    end
    @(negedge clk);
    step_i = 1'b0;
    act_i = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    sweep(0, -1);
    // R9: load fields, R5/R7/R10: general dynamics over several steps
    wr(0, 256); wr(1, 128); wr(2, 10); wr(3, 2); wr(4, 500);
    for (int s = 0; s < 3; s++) sweep(1, -1);
    // R4: strobe arrives while neuron 3 is processed
    sweep(1, 3);
    sweep(4, 5);
    // R6: wrap with maximal positive and mixed-sign activation
    wr(0, 0); wr(4, 131071);
    for (int s = 0; s < 6; s++) sweep(2, -1);
    for (int s = 0; s < 6; s++) sweep(3, -1);
    // R7/R8: positive saturation coinciding with a spike at max threshold
    wr(1, 0); wr(2, 4095); wr(3, 7);
    for (int s = 0; s < 20; s++) sweep(0, -1);
    // R7: negative saturation, mantissa -4096 encoded as 0x1000
    wr(2, 4096); wr(3, 7);
    for (int s = 0; s < 20; s++) sweep(0, -1);
    // R1 again, then R8 strict threshold: v equals 64 then 128 against threshold 64
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    wr(0, 4095); wr(1, 0); wr(2, 64); wr(3, 0); wr(4, 1);
    for (int s = 0; s < 3; s++) sweep(0, -1);
    // R5: full current decay, u equals act*64
    sweep(4, -1);
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule